// File: doc/BRIEF.md
# Crystal Frequency Estimator and Classifier

This block measures the frequency of the main oscillator that clocks it. A slow reference clock is used as the time base. Its nominal frequency is 8 MHz divided by 256, which gives a period of about 32 µs. After a start pulse, the block counts main-clock cycles across a fixed window of reference periods. It then converts the count to whole megahertz and sorts the result into one of two supported crystal classes, 26 MHz or 40 MHz.

Estimates that fall in the guard bands between the two classes still yield a guessed class, but a warning is raised. Estimates outside every band yield an unknown class. For the unknown case the resolved-frequency output falls back to 26 MHz.

Boot logic can also supply an expected crystal frequency. In that case the resolved frequency is always the supplied value, and a mismatch flag reports when the measurement disagrees with it. All results are registered when the measurement ends, together with a one-cycle done pulse.

Top module: `xtal_freq_classifier`

## Requirements
- R1: After reset, done_o, warn_o and mismatch_o are 0, est_mhz_o and freq_mhz_o are 0, and class_o is 2'b00 (unknown).
- R2: After start_i, counting begins at the first rising edge of the synchronised reference. The count stops at the 10th rising edge after that one. The count equals the number of main-clock cycles in 10 reference periods, and est_mhz_o = floor(count / 320), clamped to 255.
- R3: An estimate from 21 to 31 inclusive gives class_o = 2'b01 (26 MHz class) and warn_o = 0.
- R4: An estimate of 32 or 33 gives class_o = 2'b01 and warn_o = 1.
- R5: An estimate of 34 or 35 gives class_o = 2'b10 (40 MHz class) and warn_o = 1.
- R6: An estimate from 36 to 45 inclusive gives class_o = 2'b10 and warn_o = 0.
- R7: Any other estimate gives class_o = 2'b00 (unknown) and warn_o = 1.
- R8: With no expected value configured (exp_valid_i = 0 at start), freq_mhz_o is 40 for class 2'b10. It is 26 for class 2'b01 and for unknown, and mismatch_o is 0.
- R9: When exp_valid_i = 1 at start, freq_mhz_o is the configured value (exp_sel_i 0 = 26, 1 = 40). mismatch_o is 1 exactly when class_o differs from the configured class, and an unknown class counts as a difference.
- R10: done_o is high for exactly one cycle per completed measurement. All result outputs change only in the cycle where done_o rises, and they hold their values until the next done.
- R11: The cycle counter saturates at 2^CNT_W-1 and does not wrap.
- R12: A start_i pulse during a measurement discards that measurement and re-arms the block. Only the restarted measurement produces a done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main oscillator clock being measured |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_clk_i | input | 1 | Slow asynchronous reference clock |
| start_i | input | 1 | One-cycle pulse that clears and re-arms the measurement |
| exp_valid_i | input | 1 | An expected crystal value is configured (sampled at start) |
| exp_sel_i | input | 1 | Configured crystal: 0 = 26 MHz, 1 = 40 MHz (sampled at start) |
| done_o | output | 1 | One-cycle pulse when results are updated |
| est_mhz_o | output | 8 | Measured estimate in whole MHz |
| class_o | output | 2 | 00 unknown, 01 26 MHz class, 10 40 MHz class |
| warn_o | output | 1 | Estimate is in a guard band or out of range |
| freq_mhz_o | output | 8 | Resolved crystal frequency in MHz |
| mismatch_o | output | 1 | Configured value disagrees with the measurement |

## Verification
A wrong edge count or a missed synchronised edge shows up at done time as an estimate off by whole tenths of the window. For example, a window one period short reduces the estimate by about a tenth. Floor-division or band-limit errors show on the boundary estimates 20/21, 31/32, 33/34, 35/36 and 45/46. Each of these is measured with period lengths that leave large remainders. A counter that wraps instead of saturating is exposed by a narrow-counter instance, whose estimate would drop to near zero. Output registers that do not hold their values are caught in any cycle between two done pulses.

// File: rtl/xfc_pkg.sv
// Shared types and band limits for the crystal frequency classifier.
// Assumes estimates are whole MHz carried in 8 bits.
package xfc_pkg;

    typedef enum logic [1:0] {
        XC_UNKNOWN = 2'b00,
        XC_LOW     = 2'b01,
        XC_HIGH    = 2'b10
    } xfc_class_e;

    localparam logic [7:0] LOW_NOM_MHZ  = 8'd26;
    localparam logic [7:0] HIGH_NOM_MHZ = 8'd40;

    // Band edges, inclusive
    localparam logic [7:0] LOW_MIN   = 8'd21;
    localparam logic [7:0] LOW_MAX   = 8'd31;
    localparam logic [7:0] LGUARD_MX = 8'd33;
    localparam logic [7:0] HGUARD_MX = 8'd35;
    localparam logic [7:0] HIGH_MAX  = 8'd45;

    typedef struct packed {
        xfc_class_e cls;
        logic       warn;
    } xfc_verdict_t;

endpackage

// File: rtl/xfc_ref_sync.sv
// Brings the asynchronous reference clock into the main-clock domain
// through a two-flop synchroniser and flags each rising edge for one cycle.
// Assumes the reference is much slower than clk.
module xfc_ref_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_i,
    output logic rise_o
);
    logic [2:0] pipe_q;

    // Shift the reference through two sync stages and one history stage
    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= {pipe_q[1:0], ref_i};
    end

    assign rise_o = pipe_q[1] & ~pipe_q[2];

    // R2: detected edges are single-cycle pulses
    rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/xfc_window_counter.sv
// Counts main-clock cycles across WIN reference periods after a start
// pulse. A start at any time clears and re-arms. fin_o pulses together
// with the final, saturated count.
module xfc_window_counter #(
    parameter int CNT_W = 16,
    parameter int WIN   = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             rise_i,
    output logic             fin_o,
    output logic [CNT_W-1:0] count_o
);
    localparam int EW = $clog2(WIN + 1);
    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};
    localparam logic [EW-1:0]    ELAST = EW'(WIN - 1);

    typedef enum logic [1:0] {S_IDLE, S_ARM, S_MEAS} st_e;
    st_e              st_q;
    logic [CNT_W-1:0] cnt_q, cnt_nxt;
    logic [EW-1:0]    edg_q;

    assign cnt_nxt = (cnt_q == CMAX) ? CMAX : cnt_q + 1'b1;
    assign fin_o   = (st_q == S_MEAS) && rise_i && (edg_q == ELAST) && !start_i;
    assign count_o = cnt_nxt;

    // Sequence arm, measure and finish; start overrides everything
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= S_IDLE;
            cnt_q <= '0;
            edg_q <= '0;
        end else if (start_i) begin
            st_q  <= S_ARM;
            cnt_q <= '0;
            edg_q <= '0;
        end else begin
            case (st_q)
                S_ARM: if (rise_i) begin
                    st_q  <= S_MEAS;
                    cnt_q <= '0;
                end
                S_MEAS: begin
                    cnt_q <= cnt_nxt;
                    if (rise_i) begin
                        if (edg_q == ELAST) st_q <= S_IDLE;
                        else                edg_q <= edg_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // R11
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CMAX && !start_i) |=> (cnt_q == CMAX));
    // R12
    restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (cnt_q == '0 && st_q == S_ARM));
endmodule

// File: rtl/xfc_band_classifier.sv
// Converts a window cycle count to whole MHz and sorts it into bands.
// Assumes the reference period is REF_DIV/REF_MHZ microseconds.
module xfc_band_classifier
    import xfc_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int WIN     = 10,
    parameter int REF_DIV = 256,
    parameter int REF_MHZ = 8
) (
    input  logic [CNT_W-1:0] count_i,
    output logic [7:0]       est_o,
    output xfc_verdict_t     verdict_o
);
    localparam int DIVISOR = WIN * REF_DIV / REF_MHZ;
    localparam logic [CNT_W-1:0] DIV_C = CNT_W'(DIVISOR);
    localparam logic [CNT_W-1:0] EST_SAT = CNT_W'(255);

    logic [CNT_W-1:0] quot;

    // Floor-divide the count and clamp it to the 8-bit estimate range
    always_comb begin
        quot  = count_i / DIV_C;
        est_o = (quot > EST_SAT) ? 8'hFF : quot[7:0];
    end

    // Map the estimate onto classes and warnings
    always_comb begin
        if (est_o >= LOW_MIN && est_o <= LOW_MAX)
            verdict_o = '{cls: XC_LOW, warn: 1'b0};
        else if (est_o > LOW_MAX && est_o <= LGUARD_MX)
            verdict_o = '{cls: XC_LOW, warn: 1'b1};
        else if (est_o > LGUARD_MX && est_o <= HGUARD_MX)
            verdict_o = '{cls: XC_HIGH, warn: 1'b1};
        else if (est_o > HGUARD_MX && est_o <= HIGH_MAX)
            verdict_o = '{cls: XC_HIGH, warn: 1'b0};
        else
            verdict_o = '{cls: XC_UNKNOWN, warn: 1'b1};
    end
endmodule

// File: rtl/xtal_freq_classifier.sv
// Top: synchronises the reference, counts the window, classifies the
// estimate and registers all results on completion. It assumes clk is the
// oscillator under test and that exp_* are steady around start_i.
module xtal_freq_classifier
    import xfc_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int WIN     = 10,
    parameter int REF_DIV = 256,
    parameter int REF_MHZ = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_clk_i,
    input  logic       start_i,
    input  logic       exp_valid_i,
    input  logic       exp_sel_i,
    output logic       done_o,
    output logic [7:0] est_mhz_o,
    output logic [1:0] class_o,
    output logic       warn_o,
    output logic [7:0] freq_mhz_o,
    output logic       mismatch_o
);
    logic             rise;
    logic             fin;
    logic [CNT_W-1:0] count;
    logic [7:0]       est;
    xfc_verdict_t     verdict;
    logic             exp_v_q, exp_s_q;
    xfc_class_e       exp_cls;

    xfc_ref_sync u_sync (
        .clk(clk), .rst_n(rst_n), .ref_i(ref_clk_i), .rise_o(rise));

    xfc_window_counter #(.CNT_W(CNT_W), .WIN(WIN)) u_cnt (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .rise_i(rise),
        .fin_o(fin), .count_o(count));

    xfc_band_classifier #(.CNT_W(CNT_W), .WIN(WIN), .REF_DIV(REF_DIV),
                          .REF_MHZ(REF_MHZ)) u_cls (
        .count_i(count), .est_o(est), .verdict_o(verdict));

    assign exp_cls = exp_s_q ? XC_HIGH : XC_LOW;

    // Capture the configured expectation at each start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exp_v_q <= 1'b0;
            exp_s_q <= 1'b0;
        end else if (start_i) begin
            exp_v_q <= exp_valid_i;
            exp_s_q <= exp_sel_i;
        end
    end

    // Register results on completion and hold them until the next one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o     <= 1'b0;
            est_mhz_o  <= '0;
            class_o    <= XC_UNKNOWN;
            warn_o     <= 1'b0;
            freq_mhz_o <= '0;
            mismatch_o <= 1'b0;
        end else begin
            done_o <= fin;
            if (fin) begin
                est_mhz_o <= est;
                class_o   <= verdict.cls;
                warn_o    <= verdict.warn;
                if (exp_v_q) begin
                    freq_mhz_o <= exp_s_q ? HIGH_NOM_MHZ : LOW_NOM_MHZ;
                    mismatch_o <= (verdict.cls != exp_cls);
                end else begin
                    freq_mhz_o <= (verdict.cls == XC_HIGH) ? HIGH_NOM_MHZ : LOW_NOM_MHZ;
                    mismatch_o <= 1'b0;
                end
            end
        end
    end

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(class_o) && $stable(est_mhz_o) && $stable(freq_mhz_o)));
    // R7
    unknown_warn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && class_o == XC_UNKNOWN) |-> warn_o);
    // R8
    fallback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !exp_v_q && class_o != XC_HIGH) |-> (freq_mhz_o == LOW_NOM_MHZ && !mismatch_o));
endmodule

// File: tb/xtal_freq_classifier_tb_top.sv
// Scoreboard bench: the driver task queues the expected results of each
// measurement and the monitor compares them at every done pulse.
module xtal_freq_classifier_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_clk = 1'b0;
    logic start = 1'b0, exp_valid = 1'b0, exp_sel = 1'b0;
    logic done, warn, mism, done_s, warn_s, mism_s;
    logic [7:0] est, freq, est_s, freq_s;
    logic [1:0] cls, cls_s;

    int checks = 0, failures = 0;
    int refp = 100;
    int phase = 0;

    typedef struct {
        int p; logic [7:0] est; logic [1:0] cls; bit warn;
        logic [7:0] freq; bit mm; string tag;
    } item_t;
    item_t sb[$];

    always #2 clk = ~clk;

    xtal_freq_classifier dut_i (
        .clk(clk), .rst_n(rst_n), .ref_clk_i(ref_clk), .start_i(start),
        .exp_valid_i(exp_valid), .exp_sel_i(exp_sel), .done_o(done),
        .est_mhz_o(est), .class_o(cls), .warn_o(warn), .freq_mhz_o(freq),
        .mismatch_o(mism));

    // Narrow-counter instance exercising saturation (R11)
    xtal_freq_classifier #(.CNT_W(10)) dut_sat_i (
        .clk(clk), .rst_n(rst_n), .ref_clk_i(ref_clk), .start_i(start),
        .exp_valid_i(exp_valid), .exp_sel_i(exp_sel), .done_o(done_s),
        .est_mhz_o(est_s), .class_o(cls_s), .warn_o(warn_s), .freq_mhz_o(freq_s),
        .mismatch_o(mism_s));

    // Reference generator: period refp cycles, rise when phase wraps to 0
    always @(negedge clk) begin
        if (phase >= refp - 1) phase = 0;
        else phase = phase + 1;
        ref_clk = (phase < refp / 2);
    end

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic item_t model(int p, bit ev, bit es);
        item_t it;
        int e;
        e = (10 * p) / 320;
        it.p = p; it.est = 8'(e);
        if (e >= 21 && e <= 31)      begin it.cls = 2'b01; it.warn = 0; it.tag = "R3"; end
        else if (e >= 32 && e <= 33) begin it.cls = 2'b01; it.warn = 1; it.tag = "R4"; end
        else if (e >= 34 && e <= 35) begin it.cls = 2'b10; it.warn = 1; it.tag = "R5"; end
        else if (e >= 36 && e <= 45) begin it.cls = 2'b10; it.warn = 0; it.tag = "R6"; end
        else                         begin it.cls = 2'b00; it.warn = 1; it.tag = "R7"; end
        if (ev) begin
            it.freq = es ? 8'd40 : 8'd26;
            it.mm = (it.cls != (es ? 2'b10 : 2'b01));
        end else begin
            it.freq = (it.cls == 2'b10) ? 8'd40 : 8'd26;
            it.mm = 0;
        end
        return it;
    endfunction

    // Driver: set the period, align, queue the expectation, pulse start
    task automatic run_case(int p, bit ev, bit es, bit restart);
        refp = p;
        do @(posedge clk); while (phase != 0);
        repeat (5) @(negedge clk);
        sb.push_back(model(p, ev, es));
        exp_valid = ev; exp_sel = es; start = 1'b1;
        @(negedge clk); start = 1'b0;
        if (restart) begin
            repeat (3 * p) @(negedge clk);
            start = 1'b1;   // R12: restart mid-window
            @(negedge clk); start = 1'b0;
        end
        while (sb.size() > 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // Monitor: compare at done and watch that outputs hold between dones
    bit hold_bad = 0;
    bit prev_done = 0;
    logic [7:0] l_est = 0, l_freq = 0;
    logic [1:0] l_cls = 0;
    always @(negedge clk) if (rst_n) begin
        if (done) begin
            item_t it;
            check("R10", "hold/pulse", int'(hold_bad), 0);
            hold_bad = 0;
            if (sb.size() == 0) check("R12", "unexpected done", 1, 0);
            else begin
                it = sb.pop_front();
                check("R2", "est", est, it.est);
                check(it.tag, "class", cls, it.cls);
                check(it.tag, "warn", warn, it.warn);
                check(it.freq == 8'd26 && !it.mm && it.cls != 2'b10 ? "R8" : "R9", "freq", freq, it.freq);
                check("R9", "mismatch", mism, it.mm);
                check("R11", "sat est", est_s, ((10 * it.p > 1023) ? 1023 : 10 * it.p) / 320);
            end
            l_est = est; l_freq = freq; l_cls = cls;
        end else if (est != l_est || freq != l_freq || cls != l_cls) hold_bad = 1;
        if (done && prev_done) hold_bad = 1;
        prev_done = done;
    end

    initial begin
        fork
            begin
                repeat (195000) @(posedge clk);
                failures++;
                $display("FAIL R2 watchdog actual=hung expected=done");
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        join_none
        repeat (4) @(negedge clk);
        // R1: reset state
        check("R1", "done", done, 0);
        check("R1", "class", cls, 0);
        check("R1", "warn", warn, 0);
        check("R1", "freq", freq, 0);
        check("R1", "est", est, 0);
        check("R1", "mismatch", mism, 0);
        rst_n = 1'b1;
        @(negedge clk);
        run_case(32*20 + 31, 0, 0, 0);  // est 20: unknown, fallback 26 (R7, R8)
        run_case(32*21,      0, 0, 0);  // est 21 (R3)
        run_case(32*31 + 31, 0, 0, 0);  // est 31 with remainder (R3)
        run_case(32*32,      0, 0, 0);  // est 32 (R4)
        run_case(32*33 + 31, 1, 0, 0);  // est 33, expected 26 matches (R4, R9)
        run_case(32*34,      0, 0, 0);  // est 34 (R5)
        run_case(32*36,      0, 0, 0);  // est 36 (R6)
        run_case(32*45 + 31, 1, 1, 0);  // est 45, expected 40 matches (R6, R9)
        run_case(32*46,      1, 1, 0);  // est 46: unknown vs expected 40 (R7, R9)
        run_case(32*26,      1, 1, 1);  // restart, 26 vs expected 40 (R12, R9)
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule